// File: doc/BRIEF.md
# Overclocked symmetric FIR filter

This block is a time-multiplexed FIR filter for linear-phase (symmetric) coefficient sets. Its clock runs M times faster than the sample rate. One sample enters every M clocks, and the filter spends those M clocks working through the taps. Because the coefficients are symmetric, each tap pair is first summed in a pre-adder. That sum is then multiplied by the single stored coefficient of the pair. K multipliers therefore cover K·M tap pairs, and a filter of order N uses about N/(2M) multipliers.

The sample history is one delay line read at two points. The forward point walks the newer half with an up-counter running 0 to M-1, and the same counter addresses the coefficient ROM. The reverse point walks the older half with a down-counter running M-1 to 0, in lockstep with the up-counter. Parameter `ODD` picks the order:
- `ODD = 0` gives even order, N = 2·K·M. The reverse half starts one sample after the end of the forward half.
- `ODD = 1` gives odd order, N = 2·K·M-1. The forward half and the reverse half share the centre sample. The last ROM entry then holds half of the centre tap, because that sample passes through the pre-adder twice.

Products are accumulated at full precision. One result is emitted per input sample, together with a one-cycle valid strobe.

Top module: `sym_fir_overclock`

## Requirements
- R1: With ODD=0 the output equals y[n] = Σ_{i=0}^{N-1} h[i]·x[n-i], where N=2·K·M, h[i]=COEFS[i] for i<K·M, and h[i]=h[N-1-i] otherwise. COEFS entry j occupies bits [j·CW +: CW] as a signed value.
- R2: With ODD=1 the filter has order N=2·K·M-1 and the same symmetric form. The centre tap h[K·M-1] equals twice the last COEFS entry.
- R3: out_valid goes high for exactly one cycle, M+1 clock edges after the edge at which in_valid was sampled high.
- R4: Each accepted input produces exactly one output, and no output appears without a prior input.
- R5: out_data changes only on a cycle in which out_valid is high, and holds its value otherwise.
- R6: After reset, out_valid and out_data are 0 and the sample history is all zero. Outputs computed before N samples have arrived therefore treat the missing samples as zero.
- R7: The result is full precision. For the default width OW, samples at the extreme values −2^(DW−1) and 2^(DW−1)−1 produce the exact sum without wrap.
- R8: Inputs spaced more than M clocks apart give the same results as inputs spaced exactly M clocks apart. Idle clocks have no effect on the history or on the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, M times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, at most once every M clocks |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OW | Signed full-precision filter output |

## Verification
Checked on every cycle:
- The up-counter and the down-counter stay in lockstep, summing to M-1.
- The phase counter never reaches M.
- out_valid is never high on two adjacent cycles.
- out_valid never fires when no input is pending.
- out_data moves only together with out_valid.

Shown only by the bench scenarios, which compare against a direct-form reference:
- The arithmetic: the symmetric folding, the halved centre coefficient of the odd order, and full precision at extreme inputs.
- The exact M+1 latency.
- Insensitivity to idle gaps between samples.

These scenarios run for M = 2, 3 and 4, in both even and odd order.

// File: rtl/sym_fir_overclock.sv
module sym_fir_overclock #(
  parameter int K  = 3,
  parameter int M  = 4,
  parameter int ODD = 0,
  parameter int DW = 12,
  parameter int CW = 10,
  parameter logic [K*M*CW-1:0] COEFS = {(K*M){{(CW-3){1'b0}}, 3'b101}},
  parameter int OW = DW + CW + 2 + $clog2(K*M)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int NT = 2*K*M - ODD;
  localparam int PW = $clog2(M);

  logic signed [DW-1:0] line [NT];
  logic [PW-1:0] up, dn;
  logic busy;
  logic signed [OW-1:0] term, p, acc;
  logic pv, pfirst, plast;
  logic signed [DW:0]   pa;
  logic signed [CW-1:0] cf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) line[i] <= '0;
    end else if (in_valid) begin
      line[0] <= in_data;
      for (int i = 1; i < NT; i++) line[i] <= line[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      up   <= '0;
      dn   <= '0;
    end else if (in_valid) begin
      busy <= 1'b1;
      up   <= '0;
      dn   <= PW'(M-1);
    end else if (busy) begin
      if (up == PW'(M-1)) busy <= 1'b0;
      else begin
        up <= up + 1'b1;
        dn <= dn - 1'b1;
      end
    end
  end

  always_comb begin
    term = '0;
    pa   = '0;
    cf   = '0;
    for (int s = 0; s < K; s++) begin
      pa = {line[s*M + int'(up)][DW-1], line[s*M + int'(up)]}
         + {line[NT-M-s*M + int'(dn)][DW-1], line[NT-M-s*M + int'(dn)]};
      cf = COEFS[(s*M + int'(up))*CW +: CW];
      term = term + OW'(pa * cf);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv        <= 1'b0;
      pfirst    <= 1'b0;
      plast     <= 1'b0;
      p         <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      pv     <= busy;
      pfirst <= busy && (up == '0);
      plast  <= busy && (up == PW'(M-1));
      p      <= term;
      if (pv) acc <= pfirst ? p : acc + p;
      out_valid <= pv && plast;
      if (pv && plast) out_data <= acc + p;
    end
  end
endmodule

// File: rtl/sym_fir_overclock_chk.sv
module sym_fir_overclock_chk #(
  parameter int M  = 4,
  parameter int PW = 2,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          busy,
  input logic [PW-1:0] up,
  input logic [PW-1:0] dn,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  int pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 0;
    else pending <= pending + (in_valid ? 1 : 0) - (out_valid ? 1 : 0);
  end

  assert_lockstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(up) + int'(dn) == M-1));

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(up) < M);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pending > 0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind sym_fir_overclock sym_fir_overclock_chk #(.M(M), .PW($clog2(M)), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .up(up), .dn(dn), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sym_fir_overclock_tb_top.sv
module sym_fir_lane #(
  parameter int M   = 2,
  parameter int ODD = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int K  = 2;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int KM = K*M;
  localparam int NT = 2*KM - ODD;
  localparam int OW = DW + CW + 2 + $clog2(KM);

  function automatic int romv(int j);
    return ((j*37 + M*11 + ODD*5 + 7) % 41) - 20;
  endfunction

  function automatic logic [KM*CW-1:0] mk();
    logic [KM*CW-1:0] r;
    r = '0;
    for (int j = 0; j < KM; j++) r[j*CW +: CW] = CW'(romv(j));
    return r;
  endfunction

  localparam logic [KM*CW-1:0] ROMV = mk();

  logic in_valid;
  logic signed [DW-1:0] in_data;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  sym_fir_overclock #(.K(K), .M(M), .ODD(ODD), .DW(DW), .CW(CW), .COEFS(ROMV), .OW(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int hist[$];
  longint qv[$];
  int qc[$];
  string qs[$];
  logic signed [OW-1:0] last_out = '0;
  logic was_valid = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint tap(int i);
    int j;
    longint c;
    j = (i < KM) ? i : NT-1-i;
    c = romv(j);
    if (ODD != 0 && i == KM-1) c = 2*c;
    return c;
  endfunction

  function automatic longint ref_out();
    longint y;
    int n;
    y = 0;
    n = hist.size() - 1;
    for (int i = 0; i < NT; i++)
      if (n - i >= 0) y += tap(i) * hist[n-i];
    return y;
  endfunction

  task automatic push(int x, int gap, string tag);
    in_valid = 1'b1;
    in_data  = DW'(x);
    hist.push_back(x);
    qv.push_back(ref_out());
    qc.push_back(cyc + M + 2);
    qs.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (M - 1 + gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (was_valid && !out_valid) begin
        checks++;
        if (out_data !== last_out) begin
          fails++;
          $display("FAIL R5 M=%0d ODD=%0d hold actual=%0d expected=%0d", M, ODD, out_data, last_out);
        end
      end
      if (out_valid) begin
        checks++;
        if (qv.size() == 0) begin
          fails++;
          $display("FAIL R4 M=%0d ODD=%0d spurious output actual=%0d expected=none", M, ODD, out_data);
        end else begin
          longint ev;
          int ec;
          string et;
          ev = qv.pop_front();
          ec = qc.pop_front();
          et = qs.pop_front();
          if (longint'(out_data) != ev) begin
            fails++;
            $display("FAIL %s M=%0d ODD=%0d value actual=%0d expected=%0d", et, M, ODD, out_data, ev);
          end
          checks++;
          if (cyc != ec) begin
            fails++;
            $display("FAIL R3 M=%0d ODD=%0d latency actual=%0d expected=%0d", M, ODD, cyc, ec);
          end
        end
      end
      was_valid = out_valid;
      last_out  = out_data;
    end
  end

  initial begin
    string ft;
    done = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    ft = (ODD != 0) ? "R2" : "R1";
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R6 M=%0d ODD=%0d reset actual=%0d/%0d expected=0/0", M, ODD, out_valid, out_data);
    end
    wait (rst_n);
    @(negedge clk);
    push(1, 0, "R6");
    for (int i = 0; i < NT; i++) push(0, 0, ft);
    for (int i = 0; i < NT; i++) push(127, 0, "R7");
    for (int i = 0; i < NT; i++) push(-128, 0, "R7");
    for (int i = 0; i < 40; i++) begin
      int x, g;
      x = int'($urandom_range(255)) - 128;
      g = (i % 3 == 0) ? int'($urandom_range(3)) : 0;
      push(x, g, (g != 0) ? "R8" : ft);
    end
    repeat (M + 6) @(negedge clk);
    checks++;
    if (qv.size() != 0) begin
      fails++;
      $display("FAIL R4 M=%0d ODD=%0d missing outputs actual=%0d expected=0", M, ODD, qv.size());
    end
    done = 1'b1;
  end
endmodule

module sym_fir_overclock_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] dn;
  int cyc = 0;
  int wd_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sym_fir_lane #(.M(2), .ODD(0)) lane0 (.clk(clk), .rst_n(rst_n), .done(dn[0]));
  sym_fir_lane #(.M(2), .ODD(1)) lane1 (.clk(clk), .rst_n(rst_n), .done(dn[1]));
  sym_fir_lane #(.M(3), .ODD(0)) lane2 (.clk(clk), .rst_n(rst_n), .done(dn[2]));
  sym_fir_lane #(.M(3), .ODD(1)) lane3 (.clk(clk), .rst_n(rst_n), .done(dn[3]));
  sym_fir_lane #(.M(4), .ODD(0)) lane4 (.clk(clk), .rst_n(rst_n), .done(dn[4]));
  sym_fir_lane #(.M(4), .ODD(1)) lane5 (.clk(clk), .rst_n(rst_n), .done(dn[5]));

  initial begin
    int c, f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (dn != 6'h3f && cyc < 100000) @(negedge clk);
    if (dn != 6'h3f) begin
      wd_fail = 1;
      $display("FAIL watchdog expired actual=%0h expected=3f", dn);
    end
    c = lane0.checks + lane1.checks + lane2.checks + lane3.checks + lane4.checks + lane5.checks + wd_fail;
    f = lane0.fails + lane1.fails + lane2.fails + lane3.fails + lane4.fails + lane5.fails + wd_fail;
    $display("TB_RESULT checks=%0d failures=%0d", c, f);
    $finish;
  end
endmodule